// File: doc/BRIEF.md
# Capability Memory Access Checker

This unit decides whether a memory access may proceed under a given capability. The capability arrives already decoded into its fields: a validity tag, a sealed flag, a permission mask, a 64-bit lower bound and a 65-bit upper bound. The requested access is described by a required permission mask, a 64-bit address, a length in bytes and the number of the capability register that authorises it. The unit reports whether the access faults, a 3-bit cause code, the register number and the faulting address.

The conditions are tested in a fixed priority. Only the highest-ranked failure is reported. The bounds test computes the end of the access with a carry, so an access that runs past the top of the 64-bit address space always fails. By default the result is captured in an output register on a request strobe. A parameter can remove that register and make the unit purely combinational.

Top module: `cap_access_checker`

## Requirements
- R1: A request with a cleared tag faults with cause 1, whatever the other inputs are.
- R2: A request with a valid tag and the sealed flag set faults with cause 2.
- R3: When the capability lacks part of the required mask, and that mask is exactly one kind, the fault cause names the kind. Execute is mask bit 0 and gives cause 3. Load is bit 1 and gives cause 4. Store is bit 2 and gives cause 5.
- R4: A required mask that is missing from the capability but is not exactly one of those three single bits raises no permission fault. The bounds test then decides the result.
- R5: An access whose address is below the lower bound faults with cause 6.
- R6: An access whose address plus length carries out of 64 bits faults with cause 6, even when the upper bound is 2^64.
- R7: An access whose end (address plus length) is greater than the upper bound faults with cause 6. An end equal to the upper bound passes with cause 0.
- R8: On a fault, the fault flag is 1, the faulting address equals the access address and the register output equals the request's register number. When no check fails, the fault flag, the cause, the register output and the address output are all 0.
- R9: When several conditions fail, the cause is taken in this order: tag first, then seal, then permission, then bounds.
- R10: With the default registered stage, the outputs change one clock after a cycle with the request strobe high, and the valid output is high in exactly that cycle. After reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe |
| cap_tag | input | 1 | Capability validity tag |
| cap_sealed | input | 1 | Capability sealed flag |
| cap_perms | input | PERM_W | Permissions held by the capability |
| cap_base | input | AW | Lower bound |
| cap_top | input | AW+1 | Upper bound (exclusive) |
| req_perm | input | PERM_W | Permission mask the access needs |
| acc_addr | input | AW | Access address |
| acc_len | input | LEN_W | Access length in bytes |
| cap_reg | input | REG_W | Authorising register number |
| rsp_valid | output | 1 | Result valid |
| rsp_fault | output | 1 | Access denied |
| rsp_cause | output | 3 | Cause code, 0 when there is no fault |
| rsp_reg | output | REG_W | Register number of the faulting capability |
| rsp_badaddr | output | AW | Faulting address |

## Verification
Every result of the registered unit is due one rising edge after the edge that sees the request strobe. No field takes longer than another. The bench drives each request on a falling edge and holds it over exactly one rising edge. It then reads every output at the next falling edge, which is half a period after the capture. The strobe is lowered at that same point. An idle cycle follows, which shows the valid output drop one edge later. The bound checker ties each cause property to the inputs of the previous cycle through a single-cycle `$past`.

// File: rtl/cap_access_checker.sv
module cap_access_checker #(
  parameter int AW         = 64,
  parameter int LEN_W      = 8,
  parameter int REG_W      = 5,
  parameter int PERM_W     = 4,
  parameter int EXE_BIT    = 0,
  parameter int LOAD_BIT   = 1,
  parameter int STORE_BIT  = 2,
  parameter bit REGISTERED = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              cap_tag,
  input  logic              cap_sealed,
  input  logic [PERM_W-1:0] cap_perms,
  input  logic [AW-1:0]     cap_base,
  input  logic [AW:0]       cap_top,
  input  logic [PERM_W-1:0] req_perm,
  input  logic [AW-1:0]     acc_addr,
  input  logic [LEN_W-1:0]  acc_len,
  input  logic [REG_W-1:0]  cap_reg,
  output logic              rsp_valid,
  output logic              rsp_fault,
  output logic [2:0]        rsp_cause,
  output logic [REG_W-1:0]  rsp_reg,
  output logic [AW-1:0]     rsp_badaddr
);
  localparam logic [2:0] C_NONE  = 3'd0;
  localparam logic [2:0] C_TAG   = 3'd1;
  localparam logic [2:0] C_SEAL  = 3'd2;
  localparam logic [2:0] C_EXE   = 3'd3;
  localparam logic [2:0] C_LOAD  = 3'd4;
  localparam logic [2:0] C_STORE = 3'd5;
  localparam logic [2:0] C_LEN   = 3'd6;

  localparam logic [PERM_W-1:0] EXE_MASK   = PERM_W'(1) << EXE_BIT;
  localparam logic [PERM_W-1:0] LOAD_MASK  = PERM_W'(1) << LOAD_BIT;
  localparam logic [PERM_W-1:0] STORE_MASK = PERM_W'(1) << STORE_BIT;

  logic [AW:0]   acc_end;
  logic          perm_short, out_of_bounds;
  logic [2:0]    cause_c;
  logic          fault_c;
  logic [REG_W-1:0] reg_c;
  logic [AW-1:0]    addr_c;

  assign acc_end       = {1'b0, acc_addr} + (AW+1)'(acc_len);
  assign perm_short    = (cap_perms & req_perm) != req_perm;
  assign out_of_bounds = (acc_addr < cap_base) || acc_end[AW] || (acc_end > cap_top);

  always_comb begin
    if (!cap_tag)                                cause_c = C_TAG;
    else if (cap_sealed)                         cause_c = C_SEAL;
    else if (perm_short && req_perm == EXE_MASK)   cause_c = C_EXE;
    else if (perm_short && req_perm == LOAD_MASK)  cause_c = C_LOAD;
    else if (perm_short && req_perm == STORE_MASK) cause_c = C_STORE;
    else if (out_of_bounds)                      cause_c = C_LEN;
    else                                         cause_c = C_NONE;
  end

  assign fault_c = cause_c != C_NONE;
  assign reg_c   = fault_c ? cap_reg  : '0;
  assign addr_c  = fault_c ? acc_addr : '0;

  generate
    if (REGISTERED) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          rsp_valid   <= 1'b0;
          rsp_fault   <= 1'b0;
          rsp_cause   <= C_NONE;
          rsp_reg     <= '0;
          rsp_badaddr <= '0;
        end else begin
          rsp_valid <= req_valid;
          if (req_valid) begin
            rsp_fault   <= fault_c;
            rsp_cause   <= cause_c;
            rsp_reg     <= reg_c;
            rsp_badaddr <= addr_c;
          end
        end
      end
    end else begin : g_comb
      assign rsp_valid   = req_valid;
      assign rsp_fault   = fault_c;
      assign rsp_cause   = cause_c;
      assign rsp_reg     = reg_c;
      assign rsp_badaddr = addr_c;
    end
  endgenerate
endmodule

module cap_access_checker_sva #(
  parameter int AW         = 64,
  parameter int LEN_W      = 8,
  parameter int REG_W      = 5,
  parameter int PERM_W     = 4,
  parameter bit REGISTERED = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              cap_tag,
  input logic              cap_sealed,
  input logic [PERM_W-1:0] cap_perms,
  input logic [AW-1:0]     cap_base,
  input logic [AW:0]       cap_top,
  input logic [PERM_W-1:0] req_perm,
  input logic [AW-1:0]     acc_addr,
  input logic [LEN_W-1:0]  acc_len,
  input logic [REG_W-1:0]  cap_reg,
  input logic              rsp_valid,
  input logic              rsp_fault,
  input logic [2:0]        rsp_cause,
  input logic [REG_W-1:0]  rsp_reg,
  input logic [AW-1:0]     rsp_badaddr
);
  generate
    if (REGISTERED) begin : g_chk
      p_valid_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
      p_valid_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
      p_tag_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !cap_tag |=> rsp_fault && rsp_cause == 3'd1);
      p_seal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && cap_tag && cap_sealed |=> rsp_fault && rsp_cause == 3'd2);
      p_below_base_r5: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && cap_tag && !cap_sealed && (req_perm & ~cap_perms) == '0
          && acc_addr < cap_base |=> rsp_cause == 3'd6);
      p_fault_report_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !cap_tag |=> rsp_badaddr == $past(acc_addr) && rsp_reg == $past(cap_reg));
      p_stable_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> $stable(rsp_cause) && $stable(rsp_badaddr));
    end
  endgenerate
  always_comb if (rst_n) begin
    a_cause_range_r8: assert (rsp_cause <= 3'd6);
  end
endmodule

bind cap_access_checker cap_access_checker_sva #(
  .AW(AW), .LEN_W(LEN_W), .REG_W(REG_W), .PERM_W(PERM_W), .REGISTERED(REGISTERED)
) u_sva (.*);

// File: tb/cap_access_checker_tb_top.sv
module cap_access_checker_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        cap_tag = 1'b0, cap_sealed = 1'b0;
  logic [3:0]  cap_perms = '0, req_perm = '0;
  logic [63:0] cap_base = '0, acc_addr = '0;
  logic [64:0] cap_top = '0;
  logic [7:0]  acc_len = '0;
  logic [4:0]  cap_reg = '0;
  logic        rsp_valid, rsp_fault;
  logic [2:0]  rsp_cause;
  logic [4:0]  rsp_reg;
  logic [63:0] rsp_badaddr;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cap_access_checker dut_i (.*);

  task automatic check(input string req, input logic [64:0] got, input logic [64:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic send(input bit tag, input bit sealed, input logic [3:0] perms,
                      input logic [63:0] base, input logic [64:0] top,
                      input logic [3:0] rperm, input logic [63:0] addr,
                      input logic [7:0] len, input logic [4:0] rnum);
    @(negedge clk);
    req_valid = 1'b1; cap_tag = tag; cap_sealed = sealed; cap_perms = perms;
    cap_base = base; cap_top = top; req_perm = rperm; acc_addr = addr;
    acc_len = len; cap_reg = rnum;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic expect_rsp(input string req, input logic [2:0] cause);
    check({req, " valid"}, 65'(rsp_valid), 65'(1));
    check({req, " cause"}, 65'(rsp_cause), 65'(cause));
    check({req, " fault"}, 65'(rsp_fault), 65'(cause != 0));
    check({req, " reg"}, 65'(rsp_reg), cause != 0 ? 65'(cap_reg) : 65'(0));
    check({req, " badaddr"}, 65'(rsp_badaddr), cause != 0 ? 65'(acc_addr) : 65'(0));
  endtask

  localparam logic [64:0] TOP_MAX = 65'h1_0000_0000_0000_0000;

  task automatic t_reset;
    check("R10 reset valid", 65'(rsp_valid), 0);
    check("R10 reset fault", 65'(rsp_fault), 0);
    check("R10 reset cause", 65'(rsp_cause), 0);
    check("R10 reset badaddr", 65'(rsp_badaddr), 0);
  endtask

  task automatic t_tag;
    send(0, 1, 4'b0000, 64'h1000, 65'h2000, 4'b0001, 64'h10, 8, 5'd7);
    expect_rsp("R1 R9 tag over all", 3'd1);
  endtask

  task automatic t_seal;
    send(1, 1, 4'b0000, 64'h1000, 65'h2000, 4'b0010, 64'h10, 8, 5'd9);
    expect_rsp("R2 R9 seal over perm/bounds", 3'd2);
  endtask

  task automatic t_perm;
    send(1, 0, 4'b0110, 64'h1000, 65'h2000, 4'b0001, 64'h1000, 4, 5'd1);
    expect_rsp("R3 execute", 3'd3);
    send(1, 0, 4'b0101, 64'h1000, 65'h2000, 4'b0010, 64'h1000, 4, 5'd2);
    expect_rsp("R3 load", 3'd4);
    send(1, 0, 4'b0011, 64'h1000, 65'h2000, 4'b0100, 64'h10, 4, 5'd3);
    expect_rsp("R3 R9 store over bounds", 3'd5);
  endtask

  task automatic t_other_mask;
    send(1, 0, 4'b0000, 64'h1000, 65'h2000, 4'b1000, 64'h1800, 8, 5'd4);
    expect_rsp("R4 unknown mask passes", 3'd0);
    send(1, 0, 4'b0000, 64'h1000, 65'h2000, 4'b0011, 64'h0FFF, 1, 5'd5);
    expect_rsp("R4 multi mask to bounds", 3'd6);
  endtask

  task automatic t_bounds;
    send(1, 0, 4'b1111, 64'h1000, 65'h2000, 4'b0010, 64'h0FFF, 1, 5'd6);
    expect_rsp("R5 below base", 3'd6);
    send(1, 0, 4'b1111, 64'h1000, 65'h2000, 4'b0010, 64'h1000, 8, 5'd6);
    expect_rsp("R5 at base ok", 3'd0);
    send(1, 0, 4'b1111, 64'h1000, 65'h2000, 4'b0100, 64'h1FF8, 8, 5'd8);
    expect_rsp("R7 end equals top ok", 3'd0);
    send(1, 0, 4'b1111, 64'h1000, 65'h2000, 4'b0100, 64'h1FF8, 9, 5'd8);
    expect_rsp("R7 end past top", 3'd6);
  endtask

  task automatic t_wrap;
    send(1, 0, 4'b1111, 64'h0, TOP_MAX, 4'b0010, 64'hFFFF_FFFF_FFFF_FFFF, 1, 5'd31);
    expect_rsp("R6 carry at full top", 3'd6);
    send(1, 0, 4'b1111, 64'h0, TOP_MAX, 4'b0010, 64'hFFFF_FFFF_FFFF_FFF0, 16, 5'd30);
    expect_rsp("R6 carry 16 bytes", 3'd6);
    send(1, 0, 4'b1111, 64'h0, TOP_MAX, 4'b0010, 64'hFFFF_FFFF_FFFF_FFF0, 15, 5'd30);
    expect_rsp("R6 R8 no carry passes", 3'd0);
  endtask

  task automatic t_idle;
    @(negedge clk);
    check("R10 valid drops when idle", 65'(rsp_valid), 0);
    check("R10 result held when idle", 65'(rsp_cause), 0);
  endtask

  initial begin
    #1 t_reset();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    t_tag(); t_seal(); t_perm(); t_other_mask(); t_bounds(); t_wrap(); t_idle();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule